// File: doc/BRIEF.md
# Byte-Bus Frame Position Decoder

This block sits on a byte-wide drop bus that carries STS-1, STS-3 or VC-4 payload frames. With every byte clock it receives one data byte, a shared position marker line, a payload-envelope flag and one parity bit. It checks the parity of each byte. It also works out what the marker line means on that clock. A marker pulse while the envelope flag is low marks the C1 byte. A marker pulse while the flag is high is either a path-start (J1) marker or a pointer (V1) marker, depending on how far it lies from the most recent path start and on which frame format is selected.

From the V1 markers the block produces a one-clock strobe on the actual first pointer byte. For STS-1 and STS-3 the marker lies on that byte. For VC-4 the pointer byte trails the marker by a fixed lag. Alongside the strobe runs a column counter that reads zero on the strobe clock and advances by one each byte clock. Parity failures produce a pulse and feed a saturating counter. Markers at positions the format forbids set a sticky flag that a clear input resets.

Each byte is captured together with its configuration in one input register. Every event output therefore refers to the byte driven two clocks earlier.

Top module: `bytebus_pos_decoder`

## Requirements
- R1: After reset, c1_evt, j1_evt, v1_strobe, par_err and align_err are 0, par_err_cnt is 0 and col_cnt is all ones.
- R2: Parity defaults to odd over the 8 data bits, the marker and the SPE flag together with the parity bit. cfg_par_even=1 selects even parity. cfg_par_data_only=1 covers the data byte alone. A bad byte gives a one-clock par_err pulse two clocks after the byte is driven.
- R3: Each par_err pulse increments the 16-bit par_err_cnt in the same clock. The count holds at 65535 and never wraps.
- R4: A marker with SPE low gives a one-clock c1_evt two clocks later. It never counts as J1 or V1.
- R5: With cfg_fmt=0 (STS-1), an SPE-high marker one clock after a J1 is a V1 marker, and v1_strobe rises two clocks after it. Any other legal SPE-high marker is a J1 and gives j1_evt two clocks later.
- R6: With cfg_fmt=1 (STS-3), up to three J1 markers may arrive on consecutive clocks. An SPE-high marker three clocks after a J1 is a V1 marker, with v1_strobe two clocks after it.
- R7: With cfg_fmt=2 (VC-4), an SPE-high marker three clocks after a J1 is a V1 marker. v1_strobe rises eight clocks after that marker, because the pointer byte lies six clocks past it.
- R8: align_err is set two clocks after an illegal SPE-high marker. Illegal means two or three clocks after a J1 in STS-1, one or two clocks after a J1 in VC-4, or any SPE-high marker with cfg_fmt=3. An illegal marker produces neither j1_evt nor a strobe.
- R9: align_err is sticky. align_err_clr high at a clock edge clears it, and a new violation on the same edge wins over the clear.
- R10: col_cnt is 0 in every clock where v1_strobe is 1. Otherwise it rises by one per clock and stops at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 8 | Drop bus data byte |
| bus_mark | input | 1 | Shared C1/J1/V1 position marker |
| bus_spe | input | 1 | Payload envelope flag |
| bus_par | input | 1 | Parity bit for the byte |
| cfg_fmt | input | 2 | Format: 0 STS-1, 1 STS-3, 2 VC-4, 3 reserved |
| cfg_par_even | input | 1 | 1 selects even parity |
| cfg_par_data_only | input | 1 | 1 restricts parity to the data byte |
| align_err_clr | input | 1 | Clears the sticky alignment flag |
| c1_evt | output | 1 | C1 position pulse |
| j1_evt | output | 1 | J1 position pulse |
| v1_strobe | output | 1 | Pulse on the first pointer byte |
| col_cnt | output | 10 | Clocks since the last strobe, saturating |
| par_err | output | 1 | Parity error pulse |
| par_err_cnt | output | 16 | Saturating parity error count |
| align_err | output | 1 | Sticky marker position error |

## Verification
The assertions assume that the bus inputs and configuration carry known values at every clock after reset. Configuration travels with each byte, so it may change on any clock. The clear input is a level sampled on every edge. The stimulus drives all inputs on the falling clock edge and never leaves them undriven. It switches format and parity mode only at segment boundaries, so that each segment exercises one rule set. Random markers are dense enough to hit the illegal windows often.

// File: rtl/bpd_pkg.sv
package bpd_pkg;

  typedef enum logic [1:0] {
    FMT_STS1 = 2'd0,
    FMT_STS3 = 2'd1,
    FMT_VC4  = 2'd2,
    FMT_RSVD = 2'd3
  } bus_fmt_e;

  typedef struct packed {
    logic [7:0] data;
    logic       mark;
    logic       spe;
    logic       par;
  } bus_beat_t;

  typedef struct packed {
    bus_fmt_e fmt;
    logic     even;
    logic     data_only;
  } bus_cfg_t;

endpackage

// File: rtl/bpd_parity.sv
module bpd_parity #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_vld,
  input  logic [DATA_W-1:0] data,
  input  logic              mark,
  input  logic              spe,
  input  logic              par,
  input  logic              even,
  input  logic              data_only,
  output logic              err_q,
  output logic [CNT_W-1:0]  cnt_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             cover_x;
  logic             sum_x;
  logic             bad_c;
  logic             err_d;
  logic [CNT_W-1:0] cnt_d;

  // parity over the selected cover set, then compared with the wanted sense
  always_comb begin
    cover_x = data_only ? (^data) : (^{data, mark, spe});
    sum_x   = cover_x ^ par;
    bad_c   = beat_vld & (even ? sum_x : ~sum_x);
  end

  always_comb begin
    err_d = bad_c;
    cnt_d = cnt_q;
    if (bad_c && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      err_q <= err_d;
      cnt_q <= cnt_d;
    end
  end

  // R3: the count never wraps past its top value
  a_r3_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX))
    else $error("R3 counter left saturation");

  // R3: each error pulse below the top moves the count by exactly one
  a_r3_cnt_follows_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != CNT_MAX) ##1 err_q |-> (cnt_q == $past(cnt_q) + CNT_ONE))
    else $error("R3 counter did not follow pulse");

  // R2: without an error pulse the count stays put
  a_r2_cnt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 !err_q |-> $stable(cnt_q))
    else $error("R2 counter moved without error");

endmodule

// File: rtl/bpd_classify.sv
module bpd_classify
  import bpd_pkg::*;
#(
  parameter int HIST_D   = 3,
  parameter int STS1_OFF = 1,
  parameter int STS3_OFF = 3,
  parameter int VC4_OFF  = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     beat_vld,
  input  logic     mark,
  input  logic     spe,
  input  bus_fmt_e fmt,
  input  logic     clr,
  output logic     c1_q,
  output logic     j1_q,
  output logic     v1_c,
  output logic     v1_vc4_c,
  output logic     align_q
);

  logic [HIST_D-1:0] hist_q;
  logic [HIST_D-1:0] hist_d;
  logic              hi_c;
  logic              lo_c;
  logic              late_win;
  logic              early_win;
  logic              bad_c;
  logic              j1_c;
  logic              c1_d;
  logic              align_d;

  // J1 history windows: late = after the STS-1 pointer slot, early = before the VC-4 slot
  always_comb begin
    late_win  = 1'b0;
    early_win = 1'b0;
    for (int k = 1; k <= HIST_D; k++) begin
      if ((k > STS1_OFF) && hist_q[k-1]) late_win  = 1'b1;
      if ((k < VC4_OFF)  && hist_q[k-1]) early_win = 1'b1;
    end
  end

  always_comb begin
    hi_c     = beat_vld & mark & spe;
    lo_c     = beat_vld & mark & ~spe;
    v1_c     = 1'b0;
    bad_c    = 1'b0;
    unique case (fmt)
      FMT_STS1: begin
        v1_c  = hi_c & hist_q[STS1_OFF-1];
        bad_c = hi_c & ~hist_q[STS1_OFF-1] & late_win;
      end
      FMT_STS3: begin
        v1_c  = hi_c & hist_q[STS3_OFF-1];
      end
      FMT_VC4: begin
        v1_c  = hi_c & hist_q[VC4_OFF-1];
        bad_c = hi_c & ~hist_q[VC4_OFF-1] & early_win;
      end
      FMT_RSVD: begin
        bad_c = hi_c;
      end
    endcase
    v1_vc4_c = v1_c & (fmt == FMT_VC4);
    j1_c     = hi_c & ~v1_c & ~bad_c;
    hist_d   = {hist_q[HIST_D-2:0], j1_c};
    c1_d     = lo_c;
    align_d  = bad_c ? 1'b1 : (clr ? 1'b0 : align_q);
  end

  assign j1_q = hist_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      c1_q    <= 1'b0;
      align_q <= 1'b0;
    end else begin
      hist_q  <= hist_d;
      c1_q    <= c1_d;
      align_q <= align_d;
    end
  end

  // R4 R5: a clock carries at most one kind of position event
  a_r4_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({c1_q, j1_q}))
    else $error("R4 C1 and J1 together");

  // R4: a C1 event needs a marker with the envelope flag low one clock before
  a_r4_c1_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 c1_q |-> $past(mark & ~spe))
    else $error("R4 C1 without low-SPE marker");

  // R9: the flag holds unless cleared
  a_r9_align_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (align_q && !clr) |=> align_q)
    else $error("R9 flag dropped without clear");

  // R8: the flag only rises after an SPE-high marker
  a_r8_align_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 $rose(align_q) |-> $past(mark & spe))
    else $error("R8 flag rose without marker");

endmodule

// File: rtl/bpd_v1_align.sv
module bpd_v1_align #(
  parameter int LAG   = 6,
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v1_c,
  input  logic             v1_vc4_c,
  output logic             strobe_q,
  output logic [COL_W-1:0] col_q
);

  localparam logic [COL_W-1:0] COL_MAX = {COL_W{1'b1}};
  localparam logic [COL_W-1:0] COL_ONE = {{(COL_W-1){1'b0}}, 1'b1};

  logic [LAG-1:0]   dly_q;
  logic [LAG-1:0]   dly_d;
  logic             strobe_d;
  logic [COL_W-1:0] col_d;

  // lagged path carries only VC-4 pointer markers; others strobe at once
  generate
    if (LAG == 1) begin : g_lag_one
      assign dly_d = v1_vc4_c;
    end else begin : g_lag_many
      assign dly_d = {dly_q[LAG-2:0], v1_vc4_c};
    end
  endgenerate

  always_comb begin
    strobe_d = (v1_c & ~v1_vc4_c) | dly_q[LAG-1];
    if (strobe_d) begin
      col_d = '0;
    end else if (col_q == COL_MAX) begin
      col_d = COL_MAX;
    end else begin
      col_d = col_q + COL_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q    <= '0;
      strobe_q <= 1'b0;
      col_q    <= COL_MAX;
    end else begin
      dly_q    <= dly_d;
      strobe_q <= strobe_d;
      col_q    <= col_d;
    end
  end

  // R10: the column reads zero on every strobe
  a_r10_col_zero: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> (col_q == '0))
    else $error("R10 column not zero at strobe");

  // R10: between strobes the column steps by one until it saturates
  a_r10_col_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (col_q != COL_MAX) ##1 !strobe_q |-> (col_q == $past(col_q) + COL_ONE))
    else $error("R10 column did not step");

  // R7: the end of the lag line always yields a strobe
  a_r7_lag_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    dly_q[LAG-1] |=> strobe_q)
    else $error("R7 lagged marker lost");

endmodule

// File: rtl/bytebus_pos_decoder.sv
module bytebus_pos_decoder
  import bpd_pkg::*;
#(
  parameter int COL_W      = 10,
  parameter int ERR_CNT_W  = 16,
  parameter int VC4_V1_LAG = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           bus_data,
  input  logic                 bus_mark,
  input  logic                 bus_spe,
  input  logic                 bus_par,
  input  logic [1:0]           cfg_fmt,
  input  logic                 cfg_par_even,
  input  logic                 cfg_par_data_only,
  input  logic                 align_err_clr,
  output logic                 c1_evt,
  output logic                 j1_evt,
  output logic                 v1_strobe,
  output logic [COL_W-1:0]     col_cnt,
  output logic                 par_err,
  output logic [ERR_CNT_W-1:0] par_err_cnt,
  output logic                 align_err
);

  localparam int HIST_D = 3;

  bus_beat_t beat_q, beat_d;
  bus_cfg_t  cfg_q, cfg_d;
  logic      vld_q, vld_d;
  logic      v1_c;
  logic      v1_vc4_c;

  // input stage: byte and its configuration captured together
  always_comb begin
    beat_d.data    = bus_data;
    beat_d.mark    = bus_mark;
    beat_d.spe     = bus_spe;
    beat_d.par     = bus_par;
    cfg_d.fmt      = bus_fmt_e'(cfg_fmt);
    cfg_d.even     = cfg_par_even;
    cfg_d.data_only = cfg_par_data_only;
    vld_d          = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      cfg_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      beat_q <= beat_d;
      cfg_q  <= cfg_d;
      vld_q  <= vld_d;
    end
  end

  bpd_parity #(
    .DATA_W (8),
    .CNT_W  (ERR_CNT_W)
  ) u_parity (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_vld  (vld_q),
    .data      (beat_q.data),
    .mark      (beat_q.mark),
    .spe       (beat_q.spe),
    .par       (beat_q.par),
    .even      (cfg_q.even),
    .data_only (cfg_q.data_only),
    .err_q     (par_err),
    .cnt_q     (par_err_cnt)
  );

  bpd_classify #(
    .HIST_D   (HIST_D),
    .STS1_OFF (1),
    .STS3_OFF (3),
    .VC4_OFF  (3)
  ) u_classify (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_vld (vld_q),
    .mark     (beat_q.mark),
    .spe      (beat_q.spe),
    .fmt      (cfg_q.fmt),
    .clr      (align_err_clr),
    .c1_q     (c1_evt),
    .j1_q     (j1_evt),
    .v1_c     (v1_c),
    .v1_vc4_c (v1_vc4_c),
    .align_q  (align_err)
  );

  bpd_v1_align #(
    .LAG   (VC4_V1_LAG),
    .COL_W (COL_W)
  ) u_align (
    .clk      (clk),
    .rst_n    (rst_n),
    .v1_c     (v1_c),
    .v1_vc4_c (v1_vc4_c),
    .strobe_q (v1_strobe),
    .col_q    (col_cnt)
  );

  // R6 R5: a pointer strobe never coincides with a J1 event from the same marker path
  a_r6_strobe_not_j1_mark: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ($past(v1_c) && !$past(v1_vc4_c)) |-> (v1_strobe && !j1_evt))
    else $error("R6 direct pointer marker misrouted");

endmodule

// File: tb/bytebus_pos_decoder_test.sv
module bytebus_pos_decoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int COL_MAX    = 1023;
  localparam int CNT_MAX    = 65535;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_data;
  logic        bus_mark, bus_spe, bus_par;
  logic [1:0]  cfg_fmt;
  logic        cfg_par_even, cfg_par_data_only, align_err_clr;
  logic        c1_evt, j1_evt, v1_strobe, par_err, align_err;
  logic [9:0]  col_cnt;
  logic [15:0] par_err_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  bytebus_pos_decoder uut (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_mark(bus_mark),
    .bus_spe(bus_spe), .bus_par(bus_par), .cfg_fmt(cfg_fmt),
    .cfg_par_even(cfg_par_even), .cfg_par_data_only(cfg_par_data_only),
    .align_err_clr(align_err_clr), .c1_evt(c1_evt), .j1_evt(j1_evt),
    .v1_strobe(v1_strobe), .col_cnt(col_cnt), .par_err(par_err),
    .par_err_cnt(par_err_cnt), .align_err(align_err)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic r_c1[16], r_j1[16], r_err[16], r_par[16], r_clr[16], r_strb[16];
  int m_cnt, m_col;
  logic m_align;
  int obs_strb, obs_j1, obs_c1, obs_par, first_strb;
  logic [1:0] t_fmt;
  logic t_even, t_donly;

  function automatic void chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
    end
  endfunction

  // bit that makes a byte good under the current parity settings
  function automatic logic good_par(logic [7:0] d, logic m, logic s);
    logic c;
    c = t_donly ? (^d) : (^{d, m, s});
    return t_even ? c : ~c;
  endfunction

  task automatic step(input logic [7:0] d, input logic m, input logic s,
                      input logic p, input logic clr);
    int i0, i1, i2, o1, o2, o3;
    logic hi, v1, er, j1;
    @(negedge clk);
    i0 = cyc % 16; i1 = (cyc + 15) % 16; i2 = (cyc + 14) % 16;
    if (r_par[i2] && m_cnt != CNT_MAX) m_cnt++;
    m_col = r_strb[i0] ? 0 : ((m_col == COL_MAX) ? COL_MAX : m_col + 1);
    if (r_err[i2]) m_align = 1'b1; else if (r_clr[i1]) m_align = 1'b0;
    chk("R4 c1_evt", c1_evt, r_c1[i2]);
    chk("R5 j1_evt", j1_evt, r_j1[i2]);
    chk("R7 v1_strobe", v1_strobe, r_strb[i0]);
    chk("R10 col_cnt", col_cnt, m_col);
    chk("R2 par_err", par_err, r_par[i2]);
    chk("R3 par_err_cnt", par_err_cnt, m_cnt);
    chk("R9 align_err", align_err, m_align);
    if (v1_strobe) begin obs_strb++; if (first_strb < 0) first_strb = cyc; end
    if (j1_evt) obs_j1++;
    if (c1_evt) obs_c1++;
    if (par_err) obs_par++;
    // drive this cycle's byte
    bus_data = d; bus_mark = m; bus_spe = s; bus_par = p; align_err_clr = clr;
    cfg_fmt = t_fmt; cfg_par_even = t_even; cfg_par_data_only = t_donly;
    o1 = (cyc + 15) % 16; o2 = (cyc + 14) % 16; o3 = (cyc + 13) % 16;
    hi = m & s; v1 = 1'b0; er = 1'b0;
    case (t_fmt)
      2'd0: begin v1 = hi & r_j1[o1]; er = hi & ~v1 & (r_j1[o2] | r_j1[o3]); end
      2'd1: begin v1 = hi & r_j1[o3]; end
      2'd2: begin v1 = hi & r_j1[o3]; er = hi & ~v1 & (r_j1[o1] | r_j1[o2]); end
      default: er = hi;
    endcase
    j1 = hi & ~v1 & ~er;
    r_strb[(cyc + 8) % 16] = 1'b0;
    if (v1) begin
      if (t_fmt == 2'd2) r_strb[(cyc + 8) % 16] = 1'b1;
      else r_strb[(cyc + 2) % 16] = 1'b1;
    end
    r_j1[i0] = j1; r_err[i0] = er; r_c1[i0] = m & ~s;
    r_par[i0] = (p != good_par(d, m, s)); r_clr[i0] = clr;
    cyc++;
  endtask

  task automatic good(input logic [7:0] d, input logic m, input logic s);
    step(d, m, s, good_par(d, m, s), 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) good(8'h00, 1'b0, 1'b0);
  endtask

  task automatic clear_obs();
    obs_strb = 0; obs_j1 = 0; obs_c1 = 0; obs_par = 0; first_strb = -1;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int c0;
    void'($urandom(32'h1d5e_a7c3));
    for (int i = 0; i < 16; i++) begin
      r_c1[i] = 0; r_j1[i] = 0; r_err[i] = 0; r_par[i] = 0; r_clr[i] = 0; r_strb[i] = 0;
    end
    m_cnt = 0; m_col = COL_MAX; m_align = 1'b0;
    t_fmt = 2'd0; t_even = 1'b0; t_donly = 1'b0;
    bus_data = 8'h00; bus_mark = 0; bus_spe = 0; bus_par = 1'b1; align_err_clr = 0;
    cfg_fmt = 2'd0; cfg_par_even = 0; cfg_par_data_only = 0;
    clear_obs();
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk("R1 c1_evt", c1_evt, 0); chk("R1 v1_strobe", v1_strobe, 0);
    chk("R1 par_err_cnt", par_err_cnt, 0); chk("R1 align_err", align_err, 0);
    chk("R1 col_cnt", col_cnt, COL_MAX); chk("R1 par_err", par_err, 0);
    chk("R1 j1_evt", j1_evt, 0);
    idle(4);

    // R5 STS-1: J1 then pointer marker on the next clock
    t_fmt = 2'd0; clear_obs();
    good(8'h11, 1, 1); c0 = cyc; good(8'h22, 1, 1); idle(12);
    chk("R5 sts1 strobes", obs_strb, 1); chk("R5 sts1 j1 count", obs_j1, 1);
    chk("R5 sts1 strobe lag", first_strb, c0 + 2);
    // R8 STS-1 marker two clocks after J1 is illegal
    good(8'h00, 1, 1); idle(1); good(8'h00, 1, 1); idle(6);
    chk("R8 sts1 late marker", align_err, 1);
    idle(20);
    chk("R9 sticky hold", align_err, 1);
    step(8'h00, 0, 0, good_par(8'h00, 0, 0), 1'b1); idle(3);
    chk("R9 clear", align_err, 0);

    // R6 STS-3: three consecutive J1 and three pointer markers
    t_fmt = 2'd1; idle(4); clear_obs();
    good(8'h01, 1, 1); good(8'h02, 1, 1); good(8'h03, 1, 1);
    c0 = cyc; good(8'h04, 1, 1); good(8'h05, 1, 1); good(8'h06, 1, 1); idle(12);
    chk("R6 sts3 j1 count", obs_j1, 3); chk("R6 sts3 strobes", obs_strb, 3);
    chk("R6 sts3 first strobe", first_strb, c0 + 2);
    chk("R6 sts3 no error", align_err, 0);

    // R7 VC-4: pointer marker three after J1, strobe eight after marker
    t_fmt = 2'd2; idle(4); clear_obs();
    good(8'h0f, 1, 1); idle(2); c0 = cyc; good(8'hf0, 1, 1); idle(14);
    chk("R7 vc4 strobes", obs_strb, 1); chk("R7 vc4 strobe lag", first_strb, c0 + 8);
    good(8'h00, 1, 1); good(8'h00, 1, 1); idle(6);
    chk("R8 vc4 early marker", align_err, 1);
    step(8'h00, 0, 0, good_par(8'h00, 0, 0), 1'b1); idle(3);

    // R4 C1 marker with SPE low
    clear_obs(); good(8'h5a, 1, 0); idle(6);
    chk("R4 c1 count", obs_c1, 1); chk("R4 c1 no j1", obs_j1, 0);

    // R8 reserved format
    t_fmt = 2'd3; good(8'h00, 1, 1); idle(6);
    chk("R8 reserved fmt", align_err, 1);
    step(8'h00, 0, 0, good_par(8'h00, 0, 0), 1'b1); idle(3);
    t_fmt = 2'd0;

    // R2 parity modes with hand-computed bits
    clear_obs(); t_even = 1'b1; t_donly = 1'b0;
    step(8'h03, 0, 0, 1'b0, 1'b0); idle(4);
    chk("R2 even good", obs_par, 0);
    step(8'h03, 0, 0, 1'b1, 1'b0); idle(4);
    chk("R2 even bad", obs_par, 1);
    t_even = 1'b0; t_donly = 1'b1;
    step(8'h01, 1, 0, 1'b0, 1'b0); idle(4);
    chk("R2 data only good", obs_par, 1);
    t_donly = 1'b0;
    step(8'h01, 1, 0, 1'b0, 1'b0); idle(4);
    chk("R2 full cover bad", obs_par, 2);

    // R10 column saturation after a long quiet stretch
    idle(1100);
    chk("R10 col saturates", col_cnt, COL_MAX);

    // random segments
    for (int seg = 0; seg < 40; seg++) begin
      t_fmt = 2'($urandom_range(0, 3));
      t_even = 1'($urandom_range(0, 1));
      t_donly = 1'($urandom_range(0, 1));
      for (int i = 0; i < 500; i++) begin
        logic [7:0] d; logic m, s, fl, cl;
        d = 8'($urandom); m = ($urandom_range(0, 5) == 0); s = 1'($urandom_range(0, 3) != 0);
        fl = ($urandom_range(0, 15) == 0); cl = ($urandom_range(0, 31) == 0);
        step(d, m, s, good_par(d, m, s) ^ fl, cl);
      end
    end

    // R3 saturation of the error count
    t_fmt = 2'd0; t_even = 1'b0; t_donly = 1'b0;
    for (int i = 0; i < 65600; i++) step(8'h00, 0, 0, 1'b0, 1'b0);
    idle(4);
    chk("R3 count saturated", par_err_cnt, CNT_MAX);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule